// File: doc/BRIEF.md
# Store Multiple Word Sequencer

This unit carries out a store-multiple-word operation on its own once it receives a start command. The command names a base register, a first data register and a 16-bit signed offset. The unit first forms the starting effective address. The base is zero when the base register field is 0. Otherwise the base is the content of that register. The sign-extended offset is added to the base.

The unit then walks the general-purpose registers upward from the first data register through register 31. For each one it emits a 32-bit memory write of the register's low half. Successive writes go to addresses four bytes apart.

The register file and the memory sit outside the unit. The register file is reached through one combinational read port. The memory is reached through a write port with a valid/ready handshake. A busy flag and a one-cycle done pulse tell the issuing pipeline when the operation has finished. No special-purpose state is touched.

Top module: `stmw_seq`

## Requirements
- R1: While reset is held, and right after it, `busy_o`, `done_o` and `mem_valid_o` are low.
- R2: When `base_sel_i` is 0, the base is zero, whatever register 0 holds. Otherwise the base is the 64-bit content of the selected register.
- R3: The first write's address equals the base plus `offset_i` sign-extended to 64 bits, taken modulo 2^64.
- R4: Registers `first_reg_i` through 31 are stored in ascending order, each exactly once, so exactly 32 − `first_reg_i` writes are accepted.
- R5: The data of each write is bits 31:0 of the register being stored.
- R6: Each accepted write is followed by a write whose address is 4 higher, modulo 2^64.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the next cycle still shows `mem_valid_o` high with unchanged address and data.
- R8: `busy_o` is high from the cycle after a start is taken until the cycle in which the last write is accepted. In the cycle that follows, `done_o` is high for exactly one cycle, while `busy_o` and `mem_valid_o` are low.
- R9: A start request that arrives while `busy_o` is high is dropped. It changes neither the running sequence nor anything after it.
- R10: A start request presented in the cycle where `done_o` is high is taken, and a new operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command, taken only when idle |
| base_sel_i | input | 5 | Base register index; 0 selects a zero base |
| first_reg_i | input | 5 | First register to store |
| offset_i | input | 16 | Signed byte offset |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_addr_o | output | 5 | Register-file read index |
| rf_data_i | input | 64 | Register-file read data (same cycle) |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| mem_addr_o | output | 64 | Byte address of the write |
| mem_data_o | output | 32 | Word to be written |

## Verification
Two events can share a cycle, and both cases are tested on purpose. First, the completion pulse can coincide with a fresh start: the bench drives a new command in exactly the cycle where `done_o` is seen. It then judges the result by the new operation's first address and by `busy_o` rising without a gap. Second, a stalled handshake can coincide with ignored start requests: random start pulses carrying random fields are thrown at the unit while `mem_ready_i` is toggled at random. The bench then checks that every address and data word still follows the original command. It also checks that no further write appears once `done_o` has fired.

// File: rtl/stmw_seq.sv
module stmw_seq #(
  parameter int XLEN  = 64,
  parameter int WORDW = 32,
  parameter int NREG  = 32,
  parameter int DISPW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [4:0]         base_sel_i,
  input  logic [4:0]         first_reg_i,
  input  logic [DISPW-1:0]   offset_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [4:0]         rf_addr_o,
  input  logic [XLEN-1:0]    rf_data_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic [XLEN-1:0]    mem_addr_o,
  output logic [WORDW-1:0]   mem_data_o
);
  localparam int IDXW = 5;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG - 1);
  localparam logic [XLEN-1:0] STEP = XLEN'(WORDW / 8);

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_FETCH, S_SEND} state_t;

  state_t            state_q;
  logic [IDXW-1:0]   base_q, idx_q;
  logic [DISPW-1:0]  off_q;
  logic [XLEN-1:0]   ea_q;
  logic [WORDW-1:0]  wdata_q;
  logic              done_q;

  logic [IDXW-1:0]   idx_nxt;
  logic [XLEN-1:0]   base_val, off_ext;
  logic              accept, last;

  assign idx_nxt  = idx_q + {{(IDXW-1){1'b0}}, 1'b1};
  assign accept   = (state_q == S_SEND) && mem_ready_i;
  assign last     = (idx_q == LAST_IDX);
  assign base_val = (base_q == '0) ? '0 : rf_data_i;
  assign off_ext  = {{(XLEN-DISPW){off_q[DISPW-1]}}, off_q};

  assign rf_addr_o   = (state_q == S_BASE) ? base_q :
                       (state_q == S_SEND) ? idx_nxt : idx_q;
  assign mem_valid_o = (state_q == S_SEND);
  assign mem_addr_o  = ea_q;
  assign mem_data_o  = wdata_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      off_q   <= '0;
      ea_q    <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept && last;
      case (state_q)
        S_IDLE: if (start_i) begin
          base_q  <= base_sel_i;
          idx_q   <= first_reg_i;
          off_q   <= offset_i;
          state_q <= S_BASE;
        end
        S_BASE: begin
          ea_q    <= base_val + off_ext;
          state_q <= S_FETCH;
        end
        S_FETCH: begin
          wdata_q <= rf_data_i[WORDW-1:0];
          state_q <= S_SEND;
        end
        S_SEND: if (mem_ready_i) begin
          if (last) begin
            state_q <= S_IDLE;
          end else begin
            idx_q   <= idx_nxt;
            ea_q    <= ea_q + STEP;
            wdata_q <= rf_data_i[WORDW-1:0];
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stmw_seq_chk.sv
module stmw_seq_chk #(
  parameter int XLEN  = 64,
  parameter int WORDW = 32,
  parameter int NREG  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic [WORDW-1:0] mem_data_o,
  input logic [4:0]       idx_q
);
  localparam logic [4:0] LAST_IDX = 5'(NREG - 1);
  localparam logic [XLEN-1:0] STEP = XLEN'(WORDW / 8);

  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && mem_ready_i && idx_q != LAST_IDX |=> mem_valid_o && mem_addr_o == $past(mem_addr_o) + STEP);

  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && mem_ready_i && idx_q == LAST_IDX |=> done_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !mem_valid_o);
endmodule

bind stmw_seq stmw_seq_chk #(.XLEN(XLEN), .WORDW(WORDW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .idx_q(idx_q));

// File: tb/test_stmw_seq.sv
module test_stmw_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  base_sel = '0, first_reg = '0;
  logic [15:0] offset = '0;
  logic        busy, done, mem_valid, mem_ready = 1'b0;
  logic [4:0]  rf_addr;
  logic [63:0] rf_data, mem_addr;
  logic [31:0] mem_data;
  logic [63:0] gpr [32];

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;
  assign rf_data = gpr[rf_addr];

  stmw_seq i_stmw_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_sel_i(base_sel),
    .first_reg_i(first_reg), .offset_i(offset), .busy_o(busy), .done_o(done),
    .rf_addr_o(rf_addr), .rf_data_i(rf_data), .mem_valid_o(mem_valid),
    .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_data_o(mem_data));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ea(input logic [4:0] b, input logic [15:0] off);
    logic [63:0] base = (b == 5'd0) ? 64'd0 : gpr[b];
    return base + {{48{off[15]}}, off};
  endfunction

  task automatic fill_gpr();
    for (int i = 0; i < 32; i++) gpr[i] = {$urandom, $urandom};
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(!busy && !mem_valid && !done, "R9 no activity after operation", {busy, mem_valid, done}, 0);
    end
  endtask

  // Called just after a falling edge; leaves just after the falling edge that shows done.
  task automatic run_op(input logic [4:0] b, input logic [4:0] fr, input logic [15:0] off,
                        input int rmode, input bit poke, input bit chained);
    logic [63:0] ea = exp_ea(b, off);
    int cnt = 32 - fr, k = 0, guard = 0;
    bit fin = 0, last_acc = 0, stall = 0;
    logic [63:0] pa = '0, exp_a;
    logic [31:0] pd = '0, exp_d;
    base_sel = b; first_reg = fr; offset = off; start = 1'b1;
    while (!fin && guard < 1000) begin
      @(negedge clk);
      start = 1'b0;
      mem_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'($urandom % 2) : ($urandom % 4 == 0);
      #1; guard++;
      if (last_acc) begin
        chk(done, "R8 done pulse after last write", done, 1);
        chk(!busy && !mem_valid, "R8 busy and valid low at done", {busy, mem_valid}, 0);
        fin = 1;
      end else begin
        chk(busy, (chained && guard == 1) ? "R10 start taken in done cycle" : "R8 busy during operation", busy, 1);
        chk(!done, "R8 no early done", done, 0);
        if (stall)
          chk(mem_valid && mem_addr == pa && mem_data == pd, "R7 hold while stalled", mem_addr, pa);
        stall = 0;
        if (mem_valid) begin
          exp_a = ea + 64'(4 * k);
          exp_d = gpr[fr + k][31:0];
          chk(mem_addr == exp_a, (k == 0) ? "R2 R3 first address" : "R6 address step", mem_addr, exp_a);
          chk(mem_data == exp_d, "R5 low word of register", mem_data, exp_d);
          if (mem_ready) begin
            k++;
            if (k == cnt) last_acc = 1;
          end else begin
            stall = 1; pa = mem_addr; pd = mem_data;
          end
        end
        if (poke) begin
          start = 1'($urandom % 2);
          base_sel = 5'($urandom); first_reg = 5'($urandom); offset = 16'($urandom);
        end
      end
    end
    chk(fin, "R8 operation completes", fin, 1);
    chk(k == cnt, "R4 number of words stored", k, cnt);
    mem_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    fill_gpr();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!busy && !done && !mem_valid, "R1 quiet during reset", {busy, done, mem_valid}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !done && !mem_valid, "R1 quiet after reset", {busy, done, mem_valid}, 0);

    gpr[0] = 64'h1234_5678_9ABC_DEF0;
    run_op(5'd0, 5'd31, 16'h0010, 0, 0, 0);          // R2 zero base, R4 single word
    idle_check(2);
    run_op(5'd5, 5'd0, 16'h8000, 1, 0, 0);           // R3 negative offset, all 32 registers
    idle_check(2);
    gpr[7] = 64'hFFFF_FFFF_FFFF_FFF8;
    run_op(5'd7, 5'd28, 16'h0004, 1, 0, 0);          // R6 wraps past 2^64
    idle_check(2);
    run_op(5'd3, 5'd29, 16'h0100, 2, 0, 0);
    run_op(5'd4, 5'd30, 16'hFFF0, 1, 0, 1);          // R10 back-to-back
    idle_check(2);
    run_op(5'd9, 5'd20, 16'h0044, 1, 1, 0);          // R9 starts while busy
    idle_check(4);

    for (int n = 0; n < 40; n++) begin
      bit ch = ($urandom % 3 == 0);
      fill_gpr();
      run_op(5'($urandom), 5'($urandom), 16'($urandom), int'($urandom % 3), ($urandom % 2 == 0), 0);
      if (ch) run_op(5'($urandom), 5'($urandom), 16'($urandom), 1, 0, 1);
      idle_check(1 + int'($urandom % 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule